// File: doc/BRIEF.md
# USB Bus Idle Condition Detector

This block watches the D+ and D- lines of a low-/full-speed USB port while no packet is on the wire. It times every interval during which both lines are low (SE0). When the interval ends, it sorts the interval into one of three classes: a bus reset, a low-speed keep-alive, or neither. The timing is counted in sample-clock cycles. Both thresholds come from the clock frequency and two nanosecond parameters.

The block also keeps the speed selection that the serial receiver uses to tell J from K. In automatic mode, the idle level seen when SE0 ends sets the speed:

- D+ high alone selects full speed.
- D- high alone selects low speed.
- Both lines high leave the selection as it was.

Two fixed modes pin the selection to full or low speed. In a fixed mode, a reset therefore always leaves the configured speed in place. The block reports nothing while the line stays all-low. It classifies an interval only once a line rises again.

Top module: `usb_idle_detect`

## Requirements
- R1: An SE0 interval of more than RESET_CYC consecutive sampled cycles raises `bus_reset_pulse` for exactly one cycle after the line leaves SE0. RESET_CYC is CLK_HZ*RESET_NS/1e9, which is 25 at 10 MHz and 2500 ns.
- R2: An interval of more than KA_CYC cycles but at most RESET_CYC cycles raises `keep_alive_pulse` for one cycle, provided `speed_low` was 1 when the interval ended. KA_CYC is CLK_HZ*KA_NS/1e9, which is 12 at 10 MHz and 1200 ns.
- R3: An interval that qualifies for neither class produces no pulse. An interval never produces both pulses. A medium interval produces no keep-alive while `speed_low` is 0.
- R4: No pulse appears while both lines stay low, however long. The classification pulse appears within SYNC_STAGES+3 cycles after a line rises.
- R5: In automatic mode, the level at the end of SE0 sets the speed. D+=1,D-=0 gives `speed_low`=0. D+=0,D-=1 gives `speed_low`=1. D+=1,D-=1 leaves `speed_low` unchanged.
- R6: `speed_mode` encoding is 2'b00 automatic, 2'b01 fixed full speed, 2'b10 fixed low speed, and 2'b11 automatic. In a fixed mode, `speed_low` takes the fixed value one cycle later and holds it whatever the line does.
- R7: `j_level` gives the {D+,D-} idle pattern of the selected speed: 2'b10 for full speed and 2'b01 for low speed.
- R8: After `rst`, both pulses are 0 and `speed_low` is 0 in automatic mode.
- R9: The duration count saturates. An SE0 many times longer than RESET_CYC still yields exactly one reset pulse and no keep-alive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| line_dp | input | 1 | D+ line level, asynchronous |
| line_dm | input | 1 | D- line level, asynchronous |
| speed_mode | input | 2 | 00/11 automatic, 01 fixed full, 10 fixed low |
| bus_reset_pulse | output | 1 | One-cycle pulse: long SE0 ended |
| keep_alive_pulse | output | 1 | One-cycle pulse: medium SE0 ended at low speed |
| speed_low | output | 1 | Selected speed, 1 = low speed |
| j_level | output | 2 | {D+,D-} pattern that means J at the selected speed |

## Verification
The bench sweeps the SE0 length cycle by cycle from 1 to 30 in all four mode codes. It ends each interval with each of the three non-SE0 levels. This separates the none/keep-alive/reset boundaries at 12/13 and 25/26, and shows that the keep-alive depends on the speed held before the interval. Ending on J versus K versus SE1 tells automatic speed capture apart from the hold case and from the fixed modes. A single very long SE0 exercises counter saturation, and a mid-interval check confirms that nothing is reported before a line rises.

// File: rtl/usb_idle_pkg.sv
package usb_idle_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO     = 2'b00,
        MODE_FULL     = 2'b01,
        MODE_LOW      = 2'b10,
        MODE_AUTO_ALT = 2'b11
    } mode_e;

    typedef enum logic {
        SPD_FULL = 1'b0,
        SPD_LOW  = 1'b1
    } speed_e;

    typedef struct packed {
        logic dp;
        logic dm;
    } line_s;

    // End-of-SE0 event handed from the timer to the classifier and speed logic
    typedef struct packed {
        logic fire;      // line left SE0 this cycle
        logic over_rst;  // interval exceeded reset threshold
        logic over_ka;   // interval exceeded keep-alive threshold
    } se0_end_s;

    localparam line_s LINE_SE1 = '{dp: 1'b1, dm: 1'b1};

    function automatic int ns_to_cycles(input longint hz, input longint ns);
        return int'((hz * ns) / 64'd1_000_000_000);
    endfunction

    function automatic logic is_se0(input line_s l);
        return !l.dp && !l.dm;
    endfunction

    function automatic line_s j_pattern(input speed_e s);
        return (s == SPD_LOW) ? '{dp: 1'b0, dm: 1'b1} : '{dp: 1'b1, dm: 1'b0};
    endfunction

endpackage

// File: rtl/usb_line_sync.sv
module usb_line_sync
    import usb_idle_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_s raw,
    output line_s synced
);
    line_s stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[i] <= LINE_SE1;
                end else if (i == 0) begin
                    stage_q[i] <= raw;
                end else begin
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/usb_se0_timer.sv
module usb_se0_timer
    import usb_idle_pkg::*;
#(
    parameter int RST_CYC = 25,
    parameter int KA_CYC  = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  line_s    lvl,
    output se0_end_s ev
);
    localparam int SAT = RST_CYC + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] cnt_q;
    logic          se0_now;

    assign se0_now = is_se0(lvl);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (se0_now) begin
            if (cnt_q != CW'(SAT)) cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    always_comb begin
        ev.fire     = !se0_now && (cnt_q != '0);
        ev.over_rst = cnt_q > CW'(RST_CYC);
        ev.over_ka  = cnt_q > CW'(KA_CYC);
    end
endmodule

// File: rtl/usb_speed_sel.sv
module usb_speed_sel
    import usb_idle_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mode_e    mode,
    input  line_s    lvl,
    input  se0_end_s ev,
    output speed_e   spd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            spd <= SPD_FULL;
        end else begin
            unique case (mode)
                MODE_FULL: spd <= SPD_FULL;
                MODE_LOW:  spd <= SPD_LOW;
                default: begin
                    if (ev.fire) begin
                        if (lvl.dp && !lvl.dm)      spd <= SPD_FULL;
                        else if (lvl.dm && !lvl.dp) spd <= SPD_LOW;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/usb_idle_classify.sv
module usb_idle_classify
    import usb_idle_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  se0_end_s ev,
    input  speed_e   spd,
    output logic     reset_p,
    output logic     ka_p
);
    always_ff @(posedge clk) begin
        if (rst) begin
            reset_p <= 1'b0;
            ka_p    <= 1'b0;
        end else begin
            reset_p <= ev.fire && ev.over_rst;
            ka_p    <= ev.fire && !ev.over_rst && ev.over_ka && (spd == SPD_LOW);
        end
    end
endmodule

// File: rtl/usb_idle_detect.sv
module usb_idle_detect
    import usb_idle_pkg::*;
#(
    parameter longint CLK_HZ      = 48_000_000,
    parameter longint RESET_NS    = 2500,
    parameter longint KA_NS       = 1200,
    parameter int     SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_dp,
    input  logic       line_dm,
    input  logic [1:0] speed_mode,
    output logic       bus_reset_pulse,
    output logic       keep_alive_pulse,
    output logic       speed_low,
    output logic [1:0] j_level
);
    localparam int RST_CYC = ns_to_cycles(CLK_HZ, RESET_NS);
    localparam int KA_CYC  = ns_to_cycles(CLK_HZ, KA_NS);

    line_s    raw_l, sync_l;
    se0_end_s end_ev;
    speed_e   spd;
    line_s    jp;

    assign raw_l = '{dp: line_dp, dm: line_dm};

    usb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_l), .synced(sync_l)
    );

    usb_se0_timer #(.RST_CYC(RST_CYC), .KA_CYC(KA_CYC)) u_timer (
        .clk(clk), .rst(rst), .lvl(sync_l), .ev(end_ev)
    );

    usb_speed_sel u_speed (
        .clk(clk), .rst(rst), .mode(mode_e'(speed_mode)),
        .lvl(sync_l), .ev(end_ev), .spd(spd)
    );

    usb_idle_classify u_class (
        .clk(clk), .rst(rst), .ev(end_ev), .spd(spd),
        .reset_p(bus_reset_pulse), .ka_p(keep_alive_pulse)
    );

    assign jp        = j_pattern(spd);
    assign speed_low = (spd == SPD_LOW);
    assign j_level   = {jp.dp, jp.dm};
endmodule

// File: rtl/usb_idle_detect_chk.sv
module usb_idle_detect_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] speed_mode,
    input logic       bus_reset_pulse,
    input logic       keep_alive_pulse,
    input logic       speed_low
);
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(bus_reset_pulse && keep_alive_pulse));

    a_r1_single_reset: assert property (@(posedge clk) disable iff (rst)
        bus_reset_pulse |=> !bus_reset_pulse);

    a_r2_single_ka: assert property (@(posedge clk) disable iff (rst)
        keep_alive_pulse |=> !keep_alive_pulse);

    a_r2_ka_needs_low: assert property (@(posedge clk) disable iff (rst)
        keep_alive_pulse |-> $past(speed_low));

    a_r6_fixed_full: assert property (@(posedge clk) disable iff (rst)
        (speed_mode == 2'b01) |=> !speed_low);

    a_r6_fixed_low: assert property (@(posedge clk) disable iff (rst)
        (speed_mode == 2'b10) |=> speed_low);
endmodule

bind usb_idle_detect usb_idle_detect_chk u_chk (
    .clk(clk), .rst(rst), .speed_mode(speed_mode),
    .bus_reset_pulse(bus_reset_pulse), .keep_alive_pulse(keep_alive_pulse),
    .speed_low(speed_low)
);

// File: tb/usb_idle_detect_test.sv
module usb_idle_detect_test;
    localparam int RST_CYC = 25;   // 10 MHz * 2500 ns
    localparam int KA_CYC  = 12;   // 10 MHz * 1200 ns

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_dp = 1'b1;
    logic       line_dm = 1'b0;
    logic [1:0] speed_mode = 2'b00;
    logic       bus_reset_pulse, keep_alive_pulse, speed_low;
    logic [1:0] j_level;

    int total = 0;
    int bad = 0;
    int n_rst = 0;
    int n_ka = 0;
    int cyc = 0;
    bit exp_low = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    usb_idle_detect #(.CLK_HZ(10_000_000), .RESET_NS(2500), .KA_NS(1200), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .line_dp(line_dp), .line_dm(line_dm),
        .speed_mode(speed_mode), .bus_reset_pulse(bus_reset_pulse),
        .keep_alive_pulse(keep_alive_pulse), .speed_low(speed_low), .j_level(j_level)
    );

    always @(negedge clk) begin
        if (bus_reset_pulse)  n_rst++;
        if (keep_alive_pulse) n_ka++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic trial(input logic [1:0] mode, input int n, input logic [1:0] lvl);
        bit fixed_mode, prev_low, e_rst, e_ka;
        @(negedge clk);
        speed_mode = mode;
        repeat (3) @(negedge clk);
        fixed_mode = (mode == 2'b01) || (mode == 2'b10);
        if (fixed_mode) exp_low = (mode == 2'b10);
        prev_low = exp_low;
        n_rst = 0;
        n_ka = 0;
        line_dp = 1'b0;
        line_dm = 1'b0;
        repeat (n) @(negedge clk);
        // R4: nothing reported while the line is still all-low
        chk(n_rst == 0 && n_ka == 0, "R4 quiet during SE0", n_rst + n_ka, 0);
        {line_dp, line_dm} = lvl;
        repeat (6) @(negedge clk);
        e_rst = (n > RST_CYC);
        e_ka  = !e_rst && (n > KA_CYC) && prev_low;
        if (!fixed_mode) begin
            if (lvl == 2'b10) exp_low = 1'b0;
            else if (lvl == 2'b01) exp_low = 1'b1;
        end
        chk(n_rst == int'(e_rst), "R1 reset pulse count", n_rst, e_rst);
        chk(n_ka == int'(e_ka), "R2/R3 keep-alive pulse count", n_ka, e_ka);
        chk(speed_low == exp_low, fixed_mode ? "R6 fixed speed" : "R5 auto speed", speed_low, exp_low);
        chk(j_level == (exp_low ? 2'b01 : 2'b10), "R7 j_level", j_level, exp_low ? 1 : 2);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R8: reset state
        chk(bus_reset_pulse == 1'b0, "R8 reset pulse idle", bus_reset_pulse, 0);
        chk(keep_alive_pulse == 1'b0, "R8 keep-alive idle", keep_alive_pulse, 0);
        chk(speed_low == 1'b0, "R8 speed after reset", speed_low, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(speed_low == 1'b0 && n_rst == 0 && n_ka == 0, "R8 quiet after reset", speed_low, 0);

        for (int m = 0; m < 4; m++) begin
            for (int n = 1; n <= 30; n++) begin
                trial(m[1:0], n, 2'b01);
                trial(m[1:0], n, 2'b11);
                trial(m[1:0], n, 2'b10);
            end
        end

        // R9: very long SE0 still gives a single reset
        trial(2'b10, 400, 2'b01);
        chk(n_rst == 1 && n_ka == 0, "R9 saturated long SE0", n_rst, 1);
        trial(2'b00, 400, 2'b10);
        chk(n_rst == 1, "R9 saturated long SE0 auto", n_rst, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule